// File: doc/BRIEF.md
# Configurable Synchronous Serial Shifter

This block moves one byte at a time over a synchronous serial link, using a single shift register for both directions. A set of configuration inputs picks the role (clock master or clock follower), the wiring (a standard two-wire layout, a half-duplex layout over one wire, or a fixed-pin layout), and the master clock rate. The block sends the loaded byte and collects the incoming byte on whichever pins that configuration selects. In master mode it makes the serial clock; in follower mode it takes the serial clock from outside.

The surrounding logic sets the configuration, presents a byte on `txData`, raises `txEnable` and/or `rxEnable`, and pulses `start`. The block holds `busy` during the transfer, pulses `done` for one system clock at the end, and shows the captured byte on `rxData` from that same cycle. Each data pin and the clock pin has its own output value and output enable, so the pads outside can be tri-state buffers.

Configuration is taken at `start` and held for the whole transfer. The fixed-pin bit overrides the half-duplex bit, which in turn overrides the master/follower pin swap.

Top module: `serial_shift_engine`

## Requirements
- R1: After reset, `busy`, `done`, `mainOe` and `auxOe` are 0, `rxData` is 0x00 and `sclkOut` is 1.
- R2: With fixed-pin and half-duplex both 0 and master 1, transmit bits leave on `mainOut` and receive bits are taken from `auxIn`.
- R3: With fixed-pin and half-duplex both 0 and master 0, the pins swap: transmit bits leave on `auxOut` and receive bits are taken from `mainIn`.
- R4: With half-duplex 1 and fixed-pin 0, both directions use the main pin only, in either role; if both enables are 1, only the transmit runs and `rxData` keeps its previous value.
- R5: With fixed-pin 1, transmit always uses `mainOut` and receive always uses `auxIn`, in either role.
- R6: `sclkOe` equals the master bit: the block drives the clock pin as master and leaves it released as follower.
- R7: An output enable is 1 only on the pin that is the active transmit pin while a transfer with transmit enabled is in progress; at most one data enable is 1 at any time.
- R8: A transfer is 8 bits, most significant bit first; the transmit pin changes on the falling serial clock edge and the received bit is taken on the rising edge.
- R9: As master, each serial clock half period lasts `clkHalf`+1 system clocks (full period 2 to 256 system clocks), and `sclkOut` rests at 1 whenever no transfer is in progress.
- R10: As follower, `sclkIn` passes through a two-flop synchroniser and its edges, found in the system clock domain, step the transfer.
- R11: `done` is 1 for exactly one system clock after the eighth rising serial edge, `busy` is 0 in that cycle, and `rxData` holds the received byte in that cycle.
- R12: `start` is ignored while `busy` is 1 and when both enables are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMaster | input | 1 | 1: generate the serial clock; 0: follow an external one |
| cfgBidir | input | 1 | 1: half-duplex over the main data pin |
| cfgFixedPins | input | 1 | 1: transmit on main, receive on aux in every role |
| clkHalf | input | 7 | Master half period minus one, in system clocks |
| txEnable | input | 1 | Transmit requested for the next transfer |
| rxEnable | input | 1 | Receive requested for the next transfer |
| start | input | 1 | Begin a transfer when idle |
| txData | input | 8 | Byte loaded into the shift register at start |
| rxData | output | 8 | Last byte received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| mainIn | input | 1 | Main data pin input |
| mainOut | output | 1 | Main data pin output value |
| mainOe | output | 1 | Main data pin output enable |
| auxIn | input | 1 | Aux data pin input |
| auxOut | output | 1 | Aux data pin output value |
| auxOe | output | 1 | Aux data pin output enable |
| sclkIn | input | 1 | Serial clock pin input |
| sclkOut | output | 1 | Serial clock pin output value |
| sclkOe | output | 1 | Serial clock pin output enable |

## Verification
The hardest case to reach from the ports is the half-duplex transfer with both enables set, where the receive request must be dropped while the main pin still carries the outgoing byte; the bench drives the main input with a pattern during such a transfer and checks that `rxData` keeps the byte from the transfer before. A second hard case is a `start` arriving mid-transfer, which the bench pulses with a different `txData` and then checks that the bits on the wire still come from the first byte. In follower mode the bench acts as the clock source, with edge spacing wide enough for the synchroniser delay, and it drives the pin that should be ignored with the inverse of each data bit, so any routing mistake shows in the received byte.

// File: rtl/serial_shift_pkg.sv
package serial_shift_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic load;    // accept a new transfer, load the shift register
    logic drive;   // falling serial edge: present next transmit bit
    logic sample;  // rising serial edge: shift in the receive bit
    logic finish;  // last rising edge of the byte
  } shiftStrobe_t;

  // Pin routing held for the duration of a transfer
  typedef struct packed {
    logic txActive;
    logic rxActive;
    logic txOnMain;
    logic rxOnMain;
  } route_t;

endpackage

// File: rtl/serial_shift_ctrl.sv
module serial_shift_ctrl
  import serial_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaster,
  input  logic             cfgBidir,
  input  logic             cfgFixedPins,
  input  logic [DIV_W-1:0] clkHalf,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic             start,
  input  logic             sclkIn,
  output shiftStrobe_t     strobe,
  output route_t           route,
  output logic             busy,
  output logic             done,
  output logic             sclkOut,
  output logic             sclkOe
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic               busyR, masterR, sclkR, doneR;
  route_t             routeR, nextRoute;
  logic [DIV_W-1:0]   halfR, divCnt;
  logic [CNT_W-1:0]   bitCnt;
  logic [SYNC_STAGES:0] syncChain;

  logic accept, masterTick, extRise, extFall, riseEv, fallEv;

  // Pin selection: fixed-pin beats half-duplex, which beats the role swap
  always_comb begin
    nextRoute.txActive = txEnable;
    nextRoute.rxActive = rxEnable;
    nextRoute.txOnMain = 1'b1;
    nextRoute.rxOnMain = 1'b0;
    if (cfgFixedPins) begin
      nextRoute.rxOnMain = 1'b0;
    end else if (cfgBidir) begin
      nextRoute.rxOnMain = 1'b1;
      nextRoute.rxActive = rxEnable & ~txEnable;
    end else if (!cfgMaster) begin
      nextRoute.txOnMain = 1'b0;
      nextRoute.rxOnMain = 1'b1;
    end
  end

  assign accept     = start & ~busyR & (txEnable | rxEnable);
  assign masterTick = busyR & masterR & (divCnt == halfR);
  assign extRise    = busyR & ~masterR &  syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];
  assign extFall    = busyR & ~masterR & ~syncChain[SYNC_STAGES-1] &  syncChain[SYNC_STAGES];
  assign riseEv     = (masterTick & ~sclkR) | extRise;
  assign fallEv     = (masterTick &  sclkR) | extFall;

  assign strobe.load   = accept;
  assign strobe.drive  = fallEv;
  assign strobe.sample = riseEv;
  assign strobe.finish = riseEv & (bitCnt == LAST_BIT);

  // External clock synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[SYNC_STAGES-1:0], sclkIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyR   <= 1'b0;
      masterR <= 1'b0;
      routeR  <= '0;
      halfR   <= '0;
      divCnt  <= '0;
      sclkR   <= 1'b1;
      bitCnt  <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= strobe.finish;
      if (accept) begin
        busyR   <= 1'b1;
        masterR <= cfgMaster;
        routeR  <= nextRoute;
        halfR   <= clkHalf;
        divCnt  <= '0;
        sclkR   <= 1'b1;
        bitCnt  <= '0;
      end else if (busyR) begin
        if (masterTick) begin
          divCnt <= '0;
          sclkR  <= ~sclkR;
        end else if (masterR) begin
          divCnt <= divCnt + 1'b1;
        end
        if (riseEv) bitCnt <= bitCnt + 1'b1;
        if (strobe.finish) busyR <= 1'b0;
      end
    end
  end

  assign route   = routeR;
  assign busy    = busyR;
  assign done    = doneR;
  assign sclkOut = sclkR;
  assign sclkOe  = cfgMaster;

endmodule

// File: rtl/serial_shift_datapath.sv
module serial_shift_datapath
  import serial_shift_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftStrobe_t      strobe,
  input  route_t            route,
  input  logic              busy,
  input  logic [DATA_W-1:0] txData,
  input  logic              mainIn,
  input  logic              auxIn,
  output logic [DATA_W-1:0] rxData,
  output logic              mainOut,
  output logic              mainOe,
  output logic              auxOut,
  output logic              auxOe
);

  logic [DATA_W-1:0] shiftReg, rxDataR;
  logic              txBit, inBit;

  assign inBit = route.rxOnMain ? mainIn : auxIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxDataR  <= '0;
      txBit    <= 1'b0;
    end else begin
      if (strobe.load) begin
        shiftReg <= txData;
        txBit    <= txData[DATA_W-1];
      end else begin
        if (strobe.drive) txBit <= shiftReg[DATA_W-1];
        if (strobe.sample) begin
          shiftReg <= {shiftReg[DATA_W-2:0], inBit};
          if (strobe.finish && route.rxActive)
            rxDataR <= {shiftReg[DATA_W-2:0], inBit};
        end
      end
    end
  end

  assign rxData  = rxDataR;
  assign mainOut = txBit;
  assign auxOut  = txBit;
  assign mainOe  = busy & route.txActive &  route.txOnMain;
  assign auxOe   = busy & route.txActive & ~route.txOnMain;

endmodule

// File: rtl/serial_shift_engine.sv
module serial_shift_engine
  import serial_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMaster,
  input  logic              cfgBidir,
  input  logic              cfgFixedPins,
  input  logic [DIV_W-1:0]  clkHalf,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              start,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData,
  output logic              busy,
  output logic              done,
  input  logic              mainIn,
  output logic              mainOut,
  output logic              mainOe,
  input  logic              auxIn,
  output logic              auxOut,
  output logic              auxOe,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe
);

  shiftStrobe_t strobe;
  route_t       route;

  serial_shift_ctrl #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .cfgMaster(cfgMaster), .cfgBidir(cfgBidir), .cfgFixedPins(cfgFixedPins),
    .clkHalf(clkHalf), .txEnable(txEnable), .rxEnable(rxEnable),
    .start(start), .sclkIn(sclkIn),
    .strobe(strobe), .route(route), .busy(busy), .done(done),
    .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  serial_shift_datapath #(.DATA_W(DATA_W)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .route(route), .busy(busy),
    .txData(txData), .mainIn(mainIn), .auxIn(auxIn), .rxData(rxData),
    .mainOut(mainOut), .mainOe(mainOe), .auxOut(auxOut), .auxOe(auxOe)
  );

endmodule

// File: rtl/serial_shift_checker.sv
module serial_shift_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic cfgMaster,
  input logic cfgBidir,
  input logic cfgFixedPins,
  input logic mainOut,
  input logic mainOe,
  input logic auxOe,
  input logic sclkOut
);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_oe_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mainOe && !auxOe));

  assert_oe_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(mainOe && auxOe));

  assert_sclk_rest_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cfgMaster) |-> sclkOut);

  assert_drive_on_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && busy && $past(busy) && mainOe && $changed(mainOut))
      |-> (!sclkOut && $past(sclkOut)));

  assert_halfduplex_aux_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgBidir && !cfgFixedPins) |-> !auxOe);

endmodule

bind serial_shift_engine serial_shift_checker chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .cfgMaster(cfgMaster), .cfgBidir(cfgBidir), .cfgFixedPins(cfgFixedPins),
  .mainOut(mainOut), .mainOe(mainOe), .auxOe(auxOe), .sclkOut(sclkOut)
);

// File: tb/serial_shift_engine_test.sv
module serial_shift_engine_test;

  localparam int CLK_PERIOD = 10;
  localparam int SLAVE_HALF = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgMaster = 1'b1, cfgBidir = 1'b0, cfgFixedPins = 1'b0;
  logic [6:0] clkHalf = '0;
  logic txEnable = 1'b0, rxEnable = 1'b0, start = 1'b0;
  logic [7:0] txData = '0, rxData;
  logic busy, done;
  logic mainIn = 1'b0, auxIn = 1'b0, sclkIn = 1'b1;
  logic mainOut, mainOe, auxOut, auxOe, sclkOut, sclkOe;

  int checks = 0, fails = 0, cyc = 0;
  int doneSeen;
  logic [7:0] rxAtDone;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_shift_engine uut (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgBidir(cfgBidir),
    .cfgFixedPins(cfgFixedPins), .clkHalf(clkHalf), .txEnable(txEnable),
    .rxEnable(rxEnable), .start(start), .txData(txData), .rxData(rxData),
    .busy(busy), .done(done), .mainIn(mainIn), .mainOut(mainOut),
    .mainOe(mainOe), .auxIn(auxIn), .auxOut(auxOut), .auxOe(auxOe),
    .sclkIn(sclkIn), .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One system cycle, observed at the falling clock edge
  task automatic step();
    @(negedge clk);
    cyc++;
    if (done) begin
      doneSeen++;
      rxAtDone = rxData;
    end
  endtask

  function automatic string modeTag(input bit m, input bit b, input bit f);
    if (f)      return "R5";
    else if (b) return "R4";
    else if (m) return "R2";
    else        return "R3";
  endfunction

  function automatic bit expTxMain(input bit m, input bit b, input bit f);
    return f || b || m;
  endfunction

  function automatic bit expRxMain(input bit m, input bit b, input bit f);
    return !f && (b || !m);
  endfunction

  function automatic bit expRxActive(input bit b, input bit f, input bit te, input bit re);
    return re && (f || !b || !te);
  endfunction

  task automatic driveRx(input bit onMain, input bit v);
    if (onMain) begin mainIn = v; auxIn = ~v; end
    else begin auxIn = v; mainIn = ~v; end
  endtask

  task automatic transfer(input bit m, input bit b, input bit f, input bit te,
                          input bit re, input logic [6:0] dv,
                          input logic [7:0] tx, input logic [7:0] rx,
                          input bit pokeBusy);
    string tag = modeTag(m, b, f);
    bit txMain = expTxMain(m, b, f);
    bit rxMain = expRxMain(m, b, f);
    bit rxAct  = expRxActive(b, f, te, re);
    logic [7:0] prevRx = rxData;
    logic [7:0] expRx  = rxAct ? rx : prevRx;
    logic [7:0] txBits = '0;
    int oeBad = 0, bitIdx = 7, fall1 = -1, fall2 = -1, waitCyc = 0;
    logic prevSclk;

    cfgMaster = m; cfgBidir = b; cfgFixedPins = f; clkHalf = dv;
    txEnable = te; rxEnable = re; txData = tx; start = 1'b1;
    doneSeen = 0;
    step();
    start = 1'b0; txData = ~tx;
    chk(busy === 1'b1, "R12", "busy after accepted start", int'(busy), 1);
    chk(sclkOe === m, "R6", "clock pin enable", int'(sclkOe), int'(m));

    if (m) begin
      prevSclk = sclkOut;
      while (doneSeen == 0 && waitCyc < 6000) begin
        if (pokeBusy && waitCyc == 3) begin start = 1'b1; txData = ~tx; end
        else start = 1'b0;
        step();
        waitCyc++;
        if (prevSclk && !sclkOut) begin
          if (fall1 < 0) fall1 = cyc; else if (fall2 < 0) fall2 = cyc;
          if (bitIdx >= 0) driveRx(rxMain, rx[bitIdx]);
          bitIdx--;
          if (mainOe !== (te && txMain) || auxOe !== (te && !txMain)) oeBad++;
        end
        if (!prevSclk && sclkOut)
          txBits = {txBits[6:0], txMain ? mainOut : auxOut};
        prevSclk = sclkOut;
      end
      start = 1'b0;
      chk(fall2 - fall1 == 2 * (int'(dv) + 1), "R9", "serial clock period",
          fall2 - fall1, 2 * (int'(dv) + 1));
      chk(sclkOut === 1'b1, "R9", "clock rests high after transfer", int'(sclkOut), 1);
    end else begin
      for (int i = 7; i >= 0; i--) begin
        sclkIn = 1'b0;
        driveRx(rxMain, rx[i]);
        repeat (SLAVE_HALF) step();
        if (pokeBusy && i == 6) begin start = 1'b1; step(); start = 1'b0; end
        if (mainOe !== (te && txMain) || auxOe !== (te && !txMain)) oeBad++;
        txBits = {txBits[6:0], txMain ? mainOut : auxOut};
        sclkIn = 1'b1;
        repeat (SLAVE_HALF) step();
      end
      chk(doneSeen == 1, "R10", "follower transfer completes on external edges",
          doneSeen, 1);
    end

    repeat (2) step();
    chk(doneSeen == 1, "R11", "done pulse count", doneSeen, 1);
    chk(rxAtDone === expRx, rxAct ? tag : "R4", "received byte at done",
        int'(rxAtDone), int'(expRx));
    if (te) chk(txBits === tx, tag, "transmitted bits msb first (R8)",
                int'(txBits), int'(tx));
    chk(oeBad == 0, "R7", "output enables during transfer", oeBad, 0);
    chk(busy === 1'b0 && mainOe === 1'b0 && auxOe === 1'b0, "R7",
        "idle after done", int'({busy, mainOe, auxOe}), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();
    chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done at reset",
        int'({busy, done}), 0);
    chk(rxData === 8'h00, "R1", "rxData at reset", int'(rxData), 0);
    chk(mainOe === 1'b0 && auxOe === 1'b0, "R1", "data enables at reset",
        int'({mainOe, auxOe}), 0);
    chk(sclkOut === 1'b1, "R1", "clock idle at reset", int'(sclkOut), 1);

    // R12: start with neither enable set
    txEnable = 1'b0; rxEnable = 1'b0; start = 1'b1;
    step(); start = 1'b0; step(); step();
    chk(busy === 1'b0 && done === 1'b0, "R12", "start without enables",
        int'({busy, done}), 0);

    // Directed cases
    transfer(1, 0, 0, 1, 1, 7'd1,   8'hA5, 8'h3C, 0);  // R2
    transfer(0, 0, 0, 1, 1, 7'd0,   8'h96, 8'hE1, 0);  // R3
    transfer(1, 1, 0, 1, 1, 7'd2,   8'h5A, 8'hFF, 0);  // R4 both enables
    transfer(0, 1, 0, 0, 1, 7'd0,   8'h00, 8'hC3, 0);  // R4 receive only
    transfer(0, 1, 0, 1, 1, 7'd0,   8'h81, 8'h18, 0);  // R4 follower, both
    transfer(0, 0, 1, 1, 1, 7'd0,   8'h7E, 8'h42, 0);  // R5 follower
    transfer(1, 0, 1, 1, 1, 7'd3,   8'h24, 8'hDB, 0);  // R5 master
    transfer(1, 0, 0, 1, 1, 7'd0,   8'hF0, 8'h0F, 0);  // R9 divide by 2
    transfer(1, 0, 0, 1, 1, 7'd127, 8'h33, 8'hCC, 0);  // R9 divide by 256
    transfer(1, 0, 0, 1, 1, 7'd2,   8'hB4, 8'h4B, 1);  // R12 start while busy
    transfer(0, 0, 0, 1, 1, 7'd0,   8'h69, 8'h96, 1);  // R12 follower

    // Random mix
    for (int n = 0; n < 30; n++) begin
      bit m = 1'($urandom);
      bit b = 1'($urandom);
      bit f = ($urandom % 4) == 0;
      bit te = 1'($urandom);
      bit re = !te || 1'($urandom);
      transfer(m, b, f, te, re, 7'($urandom % 8), 8'($urandom), 8'($urandom), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule